// File: doc/BRIEF.md
# Shift-Register Prescaled Watchdog Timer

This block measures intervals of seconds or longer on a clock of a hundred megahertz or more without a wide binary counter. A free-running maximal-length shift register with XOR feedback acts as the prescaler. It starts from a fixed non-zero seed, runs through its whole native cycle of 2^n − 1 states, and is never loaded with any other value to shorten that cycle. Each time the register leaves its terminal state, which is the state that follows the seed, the block emits a one-cycle tick. A narrow binary counter counts those ticks and compares the count with a limit. When the count reaches the limit the timeout flag rises and stays high.

A build-time switch adds a second shift register of a different length. In that build a tick is produced only when both registers leave their terminal states on the same clock. If the two native periods share no factor, the tick period is the product of the two periods. The register length, or the pair of lengths, sets the prescale period, and the limit sets how many of those periods make up the interval. A kick input restarts the whole interval: it reseeds the register or registers and clears the count and the flag. With enable low the interval is frozen.

Top module: `lfsr_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, tick_o is 0, count_o is 0 and timeout_o is 0.
- R2: With one register of width W, kick low and enable high, tick_o pulses after the 2nd enabled clock that follows reset or kick, and then every 2^W − 1 enabled clocks.
- R3: tick_o is high for exactly one clock per tick event.
- R4: With the second register enabled (widths WA and WB, no common factor between 2^WA − 1 and 2^WB − 1), tick_o pulses after the 2nd enabled clock and then every (2^WA − 1)(2^WB − 1) enabled clocks, and at no other time.
- R5: count_o rises by one in the same clock as each tick_o pulse, and holds once it equals limit_i.
- R6: timeout_o rises in the clock in which count_o first equals limit_i and stays high until kick or reset.
- R7: A kick clears count_o, timeout_o and tick_o on the next clock and reseeds the register, so the next tick again comes after the 2nd enabled clock that follows the kick.
- R8: A clock with enable low and kick low produces no tick, leaves count_o unchanged and does not advance the register, so later ticks shift by the number of such clocks.
- R9: With limit_i equal to 0, timeout_o rises on the first clock after reset or kick, whatever enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance enable for registers and counter |
| kick_i | input | 1 | Restart: reseed registers, clear count and flag |
| limit_i | input | CNT_W | Number of ticks that make up the interval |
| tick_o | output | 1 | One-cycle pulse per prescaler period |
| timeout_o | output | 1 | Sticky flag, count has reached the limit |
| count_o | output | CNT_W | Ticks counted since reset or kick |

## Verification
The bench builds two copies side by side: a single 4-bit register (period 15) with a limit of 3, and a dual build with a 5-bit and a 3-bit register (periods 31 and 7, combined period 217) with a limit of 2. These short lengths put several full prescaler periods, the counter saturation, the sticky flag and a combined coincidence within a few hundred clocks, while the timing formulas stay the same as for the long default lengths. Gaps in enable, mid-run kicks and a zero limit are driven into both copies at once.

// File: rtl/lfsr_timer_pkg.sv
`timescale 1ns/1ps
package lfsr_timer_pkg;

  function automatic logic [31:0] tap_bit(input int unsigned t);
    return 32'd1 << (t - 1);
  endfunction

  // Feedback tap mask for a maximal-length XOR register of width w.
  function automatic logic [31:0] lfsr_tap_mask(input int unsigned w);
    logic [31:0] m;
    m = '0;
    case (w)
      2:  m = tap_bit(2)  | tap_bit(1);
      3:  m = tap_bit(3)  | tap_bit(2);
      4:  m = tap_bit(4)  | tap_bit(3);
      5:  m = tap_bit(5)  | tap_bit(3);
      6:  m = tap_bit(6)  | tap_bit(5);
      7:  m = tap_bit(7)  | tap_bit(6);
      8:  m = tap_bit(8)  | tap_bit(6)  | tap_bit(5) | tap_bit(4);
      9:  m = tap_bit(9)  | tap_bit(5);
      10: m = tap_bit(10) | tap_bit(7);
      11: m = tap_bit(11) | tap_bit(9);
      12: m = tap_bit(12) | tap_bit(6)  | tap_bit(4) | tap_bit(1);
      13: m = tap_bit(13) | tap_bit(4)  | tap_bit(3) | tap_bit(1);
      14: m = tap_bit(14) | tap_bit(5)  | tap_bit(3) | tap_bit(1);
      15: m = tap_bit(15) | tap_bit(14);
      16: m = tap_bit(16) | tap_bit(15) | tap_bit(13) | tap_bit(4);
      17: m = tap_bit(17) | tap_bit(14);
      18: m = tap_bit(18) | tap_bit(11);
      19: m = tap_bit(19) | tap_bit(6)  | tap_bit(2) | tap_bit(1);
      20: m = tap_bit(20) | tap_bit(17);
      21: m = tap_bit(21) | tap_bit(19);
      22: m = tap_bit(22) | tap_bit(21);
      23: m = tap_bit(23) | tap_bit(18);
      24: m = tap_bit(24) | tap_bit(23) | tap_bit(22) | tap_bit(17);
      25: m = tap_bit(25) | tap_bit(22);
      26: m = tap_bit(26) | tap_bit(6)  | tap_bit(2) | tap_bit(1);
      27: m = tap_bit(27) | tap_bit(5)  | tap_bit(2) | tap_bit(1);
      28: m = tap_bit(28) | tap_bit(25);
      29: m = tap_bit(29) | tap_bit(27);
      30: m = tap_bit(30) | tap_bit(6)  | tap_bit(4) | tap_bit(1);
      31: m = tap_bit(31) | tap_bit(28);
      32: m = tap_bit(32) | tap_bit(22) | tap_bit(2) | tap_bit(1);
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lfsr_prescaler.sv
`timescale 1ns/1ps
module lfsr_prescaler #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic kick_i,
  output logic hit_o
);
  import lfsr_timer_pkg::*;

  localparam logic [W-1:0] MASK = W'(lfsr_tap_mask(W));
  // Terminal state: the successor of the seed.
  localparam logic [W-1:0] TERM = {SEED[W-2:0], ^(SEED & MASK)};

  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = ^(state_q & MASK);
  assign hit_o = en_i && (state_q == TERM);

  always_ff @(posedge clk_i) begin
    if (rst_i || kick_i) begin
      state_q <= SEED;
    end else if (en_i) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end
endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             kick_i,
  input  logic             event_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, flag_q;

  always_comb begin
    cnt_d = cnt_q;
    if (event_i && (cnt_q != limit_i)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || kick_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= event_i;
      flag_q <= flag_q || (cnt_d == limit_i);
    end
  end

  assign tick_o    = tick_q;
  assign count_o   = cnt_q;
  assign timeout_o = flag_q;
endmodule

// File: rtl/lfsr_timer.sv
`timescale 1ns/1ps
module lfsr_timer #(
  parameter int unsigned A_WIDTH = 16,
  parameter int unsigned A_SEED  = 1,
  parameter bit          DUAL    = 1'b0,
  parameter int unsigned B_WIDTH = 15,
  parameter int unsigned B_SEED  = 1,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] count_o
);
  logic hit_a;
  logic tick_event;

  lfsr_prescaler #(
    .W    (A_WIDTH),
    .SEED (A_WIDTH'(A_SEED))
  ) u_pre_a (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .kick_i (kick_i),
    .hit_o  (hit_a)
  );

  generate
    if (DUAL) begin : g_dual
      logic hit_b;
      lfsr_prescaler #(
        .W    (B_WIDTH),
        .SEED (B_WIDTH'(B_SEED))
      ) u_pre_b (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .kick_i (kick_i),
        .hit_o  (hit_b)
      );
      assign tick_event = hit_a && hit_b;
    end else begin : g_single
      assign tick_event = hit_a;
    end
  endgenerate

  tick_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .kick_i    (kick_i),
    .event_i   (tick_event),
    .limit_i   (limit_i),
    .tick_o    (tick_o),
    .count_o   (count_o),
    .timeout_o (timeout_o)
  );
endmodule

// File: rtl/lfsr_timer_chk.sv
`timescale 1ns/1ps
module lfsr_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             kick_i,
  input logic             tick_o,
  input logic             timeout_o,
  input logic [CNT_W-1:0] count_o
);
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o); // R3

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !kick_i |=> ((count_o == $past(count_o)) ||
                 (tick_o && (count_o == $past(count_o) + 1'b1)))); // R5

  AST_TIMEOUT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (timeout_o && !kick_i) |=> timeout_o); // R6

  AST_KICK_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    kick_i |=> (count_o == '0 && !timeout_o && !tick_o)); // R7

  AST_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !kick_i) |=> (!tick_o && $stable(count_o))); // R8
endmodule

bind lfsr_timer lfsr_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .kick_i    (kick_i),
  .tick_o    (tick_o),
  .timeout_o (timeout_o),
  .count_o   (count_o)
);

// File: tb/lfsr_timer_tb.sv
`timescale 1ns/1ps
module lfsr_timer_tb;
  localparam int CW = 8;
  localparam int PS = 15;   // single build, 4-bit register
  localparam int PA = 31;   // dual build, 5-bit register
  localparam int PB = 7;    // dual build, 3-bit register

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic en_i = 1'b0;
  logic kick_i = 1'b0;
  logic [CW-1:0] lim_s = 8'd3;
  logic [CW-1:0] lim_d = 8'd2;
  logic tk_s, to_s, tk_d, to_d;
  logic [CW-1:0] cnt_s, cnt_d;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lfsr_timer #(.A_WIDTH(4), .DUAL(1'b0), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .kick_i(kick_i), .limit_i(lim_s),
    .tick_o(tk_s), .timeout_o(to_s), .count_o(cnt_s));

  lfsr_timer #(.A_WIDTH(5), .DUAL(1'b1), .B_WIDTH(3), .CNT_W(CW)) u_dut_dual (
    .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .kick_i(kick_i), .limit_i(lim_d),
    .tick_o(tk_d), .timeout_o(to_d), .count_o(cnt_d));

  // Scoreboard queues, one entry per clock.
  int    q_tks[$], q_cns[$], q_tos[$];
  int    q_tkd[$], q_cnd[$], q_tod[$];
  string q_tag[$];

  // Bench model state.
  int ns_en, ns_all, ns_tk;
  int nd_en, nd_all, nd_tk;
  string tag = "R1";

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic mdl(input bit en, input bit kk, input int pa, input int pb,
                     input int lim, inout int nen, inout int nall, inout int ntk,
                     output int et, output int ec, output int eto);
    et = 0;
    if (kk) begin
      nen = 0; nall = 0; ntk = 0;
    end else begin
      nall++;
      if (en) begin
        nen++;
        if (nen >= 2 && ((nen - 2) % pa == 0) && ((nen - 2) % pb == 0)) et = 1;
        ntk += et;
      end
    end
    ec  = (ntk < lim) ? ntk : lim;
    eto = (nall >= 1 && ntk >= lim) ? 1 : 0;
  endtask

  // Driver: apply one clock of stimulus and push the expected outputs.
  task automatic step(input bit en, input bit kk);
    int et, ec, eto;
    en_i = en; kick_i = kk;
    mdl(en, kk, PS, 1, int'(lim_s), ns_en, ns_all, ns_tk, et, ec, eto);
    q_tks.push_back(et); q_cns.push_back(ec); q_tos.push_back(eto);
    mdl(en, kk, PA, PB, int'(lim_d), nd_en, nd_all, nd_tk, et, ec, eto);
    q_tkd.push_back(et); q_cnd.push_back(ec); q_tod.push_back(eto);
    q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  // Monitor: compare outputs away from the active edge.
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk(t, "single tick",    int'(tk_s),  q_tks.pop_front());
      chk(t, "single count",   int'(cnt_s), q_cns.pop_front());
      chk(t, "single timeout", int'(to_s),  q_tos.pop_front());
      chk(t, "dual tick",      int'(tk_d),  q_tkd.pop_front());
      chk(t, "dual count",     int'(cnt_d), q_cnd.pop_front());
      chk(t, "dual timeout",   int'(to_d),  q_tod.pop_front());
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs during reset
    chk("R1", "reset tick",    int'(tk_s | tk_d),   0);
    chk("R1", "reset count",   int'(cnt_s | cnt_d), 0);
    chk("R1", "reset timeout", int'(to_s | to_d),   0);
    ns_en = 0; ns_all = 0; ns_tk = 0;
    nd_en = 0; nd_all = 0; nd_tk = 0;
    rst_i = 1'b0;

    // R1 first cycle, then R2/R3/R5/R6 single period, R4 dual coincidence
    tag = "R1";
    step(1'b1, 1'b0);
    tag = "R2 R3 R4 R5 R6";
    repeat (240) step(1'b1, 1'b0);

    // R7: kick mid-run, interval restarts
    tag = "R7";
    step(1'b1, 1'b1);
    repeat (40) step(1'b1, 1'b0);

    // R8: enable gaps freeze register and counter
    tag = "R8";
    for (int i = 0; i < 120; i++) step((i % 3) != 0, 1'b0);
    repeat (4) step(1'b0, 1'b0);

    // R9: zero limit, flag on first clock after kick even with enable low
    tag = "R9";
    lim_s = '0; lim_d = '0;
    step(1'b0, 1'b1);
    repeat (3) step(1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b0);

    // R7 again with restored limits and a kick while enable is low
    tag = "R7";
    lim_s = 8'd3; lim_d = 8'd2;
    step(1'b0, 1'b1);
    repeat (60) step(1'b1, 1'b0);

    @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule